// File: doc/BRIEF.md
# Banked Vector Memory with Strided and Indexed Access

This block is the memory end of a vector load/store path. A single command names a start address, an access pattern and an element count. The pattern is either a constant stride or a vector of per-element offsets. The block walks the elements in order and presents at most one element to the memory per clock. The memory is a set of independently addressed single-port banks. The low address bits pick the bank and the remaining bits pick the word inside it.

After an access, a bank cannot accept another access for a fixed number of cycles. When the next element in order maps to a bank that is still recovering, the whole stream waits. No later element may overtake it. A counter records how many cycles the current command spent waiting, so the cost of a stride or index pattern can be compared with the bank count.

Load data comes back in element order after a fixed latency from issue, tagged with its element number. Store data is written at issue. A new command is accepted only when the previous one has issued every element and returned all of its load data.

Top module: `vmem_stride_unit`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `stall_cycles` are all 0.
- R2: In strided mode (`indexed`=0), element i uses address (`base` + i*`stride`) mod 2^ADDR_W. A stride of all ones steps downward. The bank is the low log2(NUM_BANKS) address bits and the word within the bank is the remaining upper bits.
- R3: Once a bank is accessed in cycle c, it accepts no further access before cycle c+BANK_BUSY (default 6). This holds for loads and stores alike. An element aimed at such a bank waits until the bank frees.
- R4: In indexed mode (`indexed`=1), element i uses address (`base` + idx_i) mod 2^ADDR_W. idx_i sits at `idx_vec`[i*ADDR_W +: ADDR_W], and store data for element i sits at `wdata_vec`[i*DATA_W +: DATA_W].
- R5: Elements issue strictly in order, at most one per cycle, and a waiting element holds back all later ones. Element 0 is offered in the cycle after `start` is accepted. With no bank conflicts, n elements issue in n consecutive cycles.
- R6: A load element issued in cycle c appears on `rd_data` with `rd_valid`=1 in cycle c+LOAD_LAT (default 12), with `rd_elem`=i. Results therefore come back in element order.
- R7: A store (`is_store`=1) writes element i's data at its address, and a later load of that address returns it.
- R8: `stall_cycles` clears when a command is accepted. It then rises by one for each cycle in which the next element waits on a busy bank.
- R9: `start` is ignored while `busy` is 1. A `vlen` of 0 issues nothing but still clears `stall_cycles`. A `vlen` above MAX_LEN (default 16) is treated as MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken when not busy |
| is_store | input | 1 | 1 = store command, 0 = load command |
| indexed | input | 1 | 1 = offsets from idx_vec, 0 = constant stride |
| base | input | ADDR_W | Start address |
| stride | input | ADDR_W | Element-to-element address step |
| vlen | input | LEN_W | Element count |
| idx_vec | input | MAX_LEN*ADDR_W | Per-element offsets, element i in slice i |
| wdata_vec | input | MAX_LEN*DATA_W | Per-element store data, element i in slice i |
| busy | output | 1 | Command issuing or load data still in flight |
| rd_valid | output | 1 | Load result valid this cycle |
| rd_data | output | DATA_W | Load result |
| rd_elem | output | IDX_W | Element number of the load result |
| stall_cycles | output | STALL_W | Waiting cycles of the current command |

## Verification
The in-design properties assume that `rst_n` is asserted before the first command. They also assume the default parameters keep LOAD_LAT at least 2 and BANK_BUSY at least 1. The return-order property assumes every load command begins its results at element 0. The block itself guarantees this, so no restriction is placed on the commands themselves.

The bench predicts issue cycles with its own per-bank recovery model, and it starts that model from idle banks. To keep that valid, after `busy` falls it waits longer than the bank recovery time before issuing the next command. The one deliberate exception is a `start` pulsed during a running command, which checks that such a pulse is dropped.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

  typedef enum logic {
    AM_STRIDE = 1'b0,
    AM_INDEX  = 1'b1
  } amode_e;

  // requested element count limited to the largest supported vector
  function automatic int clamp_len(input int req, input int max_len);
    return (req > max_len) ? max_len : req;
  endfunction

  // width of a down-counter able to hold the value n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/vmem_bank.sv
module vmem_bank #(
  parameter int DATA_W = 16,
  parameter int ROW_W  = 5,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store_arr [ROWS];

  always_ff @(posedge clk) begin
    if (we) store_arr[row] <= wdata;
    if (re) rdata <= store_arr[row];
  end

endmodule

// File: rtl/vmem_busy_track.sv
module vmem_busy_track #(
  parameter int NUM_BANKS = 8,
  parameter int BUSY      = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CW       = vmem_pkg::cnt_width(BUSY)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iss_vld,
  input  logic [BANK_W-1:0]    iss_bank,
  output logic [NUM_BANKS-1:0] bank_free
);

  logic [NUM_BANKS-1:0] hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CW-1:0] remain_q;

    assign hit[b]       = iss_vld && (iss_bank == BANK_W'(b));
    assign bank_free[b] = (remain_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 remain_q <= '0;
      else if (hit[b])            remain_q <= CW'(BUSY - 1);
      else if (remain_q != '0)    remain_q <= remain_q - 1'b1;
    end

    if (BUSY > 1) begin : g_chk
      AST_BANK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        hit[b] |=> !hit[b]); // R3
    end
  end

endmodule

// File: rtl/vmem_agen.sv
module vmem_agen #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAX_LEN   = 16,
  parameter int NUM_BANKS = 8,
  parameter int STALL_W   = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      is_store,
  input  logic                      indexed,
  input  logic [ADDR_W-1:0]         base,
  input  logic [ADDR_W-1:0]         stride,
  input  logic [LEN_W-1:0]          vlen,
  input  logic [MAX_LEN*ADDR_W-1:0] idx_vec,
  input  logic [MAX_LEN*DATA_W-1:0] wdata_vec,
  input  logic                      pipe_busy,
  input  logic [NUM_BANKS-1:0]      bank_free,
  output logic                      active,
  output logic                      iss_vld,
  output logic                      iss_store,
  output logic [BANK_W-1:0]         iss_bank,
  output logic [ROW_W-1:0]          iss_row,
  output logic [DATA_W-1:0]         iss_wdata,
  output logic [IDX_W-1:0]          iss_elem,
  output logic                      stall,
  output logic [STALL_W-1:0]        stall_cycles
);
  import vmem_pkg::*;

  logic                      active_q;
  logic [IDX_W-1:0]          elem_q;
  logic [IDX_W-1:0]          last_q;
  logic                      store_q;
  amode_e                    mode_q;
  logic [ADDR_W-1:0]         base_q;
  logic [ADDR_W-1:0]         stride_q;
  logic [MAX_LEN*ADDR_W-1:0] idx_q;
  logic [MAX_LEN*DATA_W-1:0] wdat_q;
  logic [STALL_W-1:0]        stall_q;

  logic              accept;
  logic [LEN_W-1:0]  len_eff;
  logic [ADDR_W-1:0] cur_addr;

  function automatic logic [ADDR_W-1:0] stride_addr(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] s,
    input logic [IDX_W-1:0] i);
    logic [ADDR_W-1:0] step;
    step = ADDR_W'(i);
    return b + s * step;
  endfunction

  function automatic logic [ADDR_W-1:0] index_addr(
    input logic [ADDR_W-1:0] b, input logic [ADDR_W-1:0] off);
    return b + off;
  endfunction

  assign len_eff  = LEN_W'(clamp_len(int'(vlen), MAX_LEN));
  assign accept   = start && !active_q && !pipe_busy;
  assign cur_addr = (mode_q == AM_INDEX)
                  ? index_addr(base_q, idx_q[elem_q*ADDR_W +: ADDR_W])
                  : stride_addr(base_q, stride_q, elem_q);

  assign iss_bank     = cur_addr[BANK_W-1:0];
  assign iss_row      = cur_addr[ADDR_W-1:BANK_W];
  assign iss_vld      = active_q && bank_free[iss_bank];
  assign stall        = active_q && !bank_free[iss_bank];
  assign iss_store    = store_q;
  assign iss_elem     = elem_q;
  assign iss_wdata    = wdat_q[elem_q*DATA_W +: DATA_W];
  assign active       = active_q;
  assign stall_cycles = stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      elem_q   <= '0;
      last_q   <= '0;
      store_q  <= 1'b0;
      mode_q   <= AM_STRIDE;
      base_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      wdat_q   <= '0;
      stall_q  <= '0;
    end else if (accept) begin
      stall_q <= '0;
      if (len_eff != '0) begin
        active_q <= 1'b1;
        elem_q   <= '0;
        last_q   <= IDX_W'(len_eff - LEN_W'(1));
        store_q  <= is_store;
        mode_q   <= indexed ? AM_INDEX : AM_STRIDE;
        base_q   <= base;
        stride_q <= stride;
        idx_q    <= idx_vec;
        wdat_q   <= wdata_vec;
      end
    end else if (active_q) begin
      if (iss_vld) begin
        if (elem_q == last_q) active_q <= 1'b0;
        else                  elem_q   <= elem_q + 1'b1;
      end else begin
        stall_q <= stall_q + 1'b1;
      end
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> active_q && (elem_q == $past(elem_q))); // R5

  AST_ELEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && (elem_q != last_q)) |=> (elem_q == $past(elem_q) + 1'b1)); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active_q) |=> ($stable(base_q) && $stable(stride_q) && $stable(last_q))); // R9

endmodule

// File: rtl/vmem_ret_pipe.sv
module vmem_ret_pipe #(
  parameter int LAT    = 12,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 4,
  localparam int NS    = LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IDX_W-1:0]  in_elem,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [IDX_W-1:0]  out_elem,
  output logic [DATA_W-1:0] out_data,
  output logic              pending
);

  logic [NS-1:0]     v_q;
  logic [IDX_W-1:0]  e_q [NS];
  logic [DATA_W-1:0] d_q [NS];
  logic [IDX_W-1:0]  prev_q;

  for (genvar s = 0; s < NS; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0; e_q[0] <= '0; d_q[0] <= '0;
        end else begin
          v_q[0] <= in_vld; e_q[0] <= in_elem; d_q[0] <= in_data;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[s] <= 1'b0; e_q[s] <= '0; d_q[s] <= '0;
        end else begin
          v_q[s] <= v_q[s-1]; e_q[s] <= e_q[s-1]; d_q[s] <= d_q[s-1];
        end
      end
    end
  end

  assign out_vld  = v_q[NS-1];
  assign out_elem = e_q[NS-1];
  assign out_data = d_q[NS-1];
  assign pending  = in_vld | (|v_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (out_vld) prev_q <= out_elem;
  end

  AST_RETURN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && (out_elem != '0)) |-> (out_elem == prev_q + 1'b1)); // R6

endmodule

// File: rtl/vmem_stride_unit.sv
module vmem_stride_unit #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int NUM_BANKS = 8,
  parameter int BANK_BUSY = 6,
  parameter int LOAD_LAT  = 12,
  parameter int MAX_LEN   = 16,
  parameter int STALL_W   = 16,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ROW_W    = ADDR_W - BANK_W,
  localparam int LEN_W    = $clog2(MAX_LEN + 1),
  localparam int IDX_W    = $clog2(MAX_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      is_store,
  input  logic                      indexed,
  input  logic [ADDR_W-1:0]         base,
  input  logic [ADDR_W-1:0]         stride,
  input  logic [LEN_W-1:0]          vlen,
  input  logic [MAX_LEN*ADDR_W-1:0] idx_vec,
  input  logic [MAX_LEN*DATA_W-1:0] wdata_vec,
  output logic                      busy,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic [IDX_W-1:0]          rd_elem,
  output logic [STALL_W-1:0]        stall_cycles
);

  logic                 active, pend;
  logic                 iss_vld, iss_store, stall;
  logic [BANK_W-1:0]    iss_bank;
  logic [ROW_W-1:0]     iss_row;
  logic [DATA_W-1:0]    iss_wdata;
  logic [IDX_W-1:0]     iss_elem;
  logic [NUM_BANKS-1:0] bank_free;
  logic [DATA_W-1:0]    bank_rd [NUM_BANKS];

  logic              a_vld;
  logic [IDX_W-1:0]  a_elem;
  logic [BANK_W-1:0] a_bank;

  vmem_agen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_LEN(MAX_LEN),
    .NUM_BANKS(NUM_BANKS), .STALL_W(STALL_W)
  ) i_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .indexed(indexed), .base(base), .stride(stride), .vlen(vlen),
    .idx_vec(idx_vec), .wdata_vec(wdata_vec), .pipe_busy(pend),
    .bank_free(bank_free), .active(active), .iss_vld(iss_vld),
    .iss_store(iss_store), .iss_bank(iss_bank), .iss_row(iss_row),
    .iss_wdata(iss_wdata), .iss_elem(iss_elem), .stall(stall),
    .stall_cycles(stall_cycles)
  );

  vmem_busy_track #(.NUM_BANKS(NUM_BANKS), .BUSY(BANK_BUSY)) i_busy (
    .clk(clk), .rst_n(rst_n), .iss_vld(iss_vld), .iss_bank(iss_bank),
    .bank_free(bank_free)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_mem
    logic sel;
    assign sel = iss_vld && (iss_bank == BANK_W'(b));
    vmem_bank #(.DATA_W(DATA_W), .ROW_W(ROW_W)) i_bank (
      .clk(clk), .we(sel && iss_store), .re(sel && !iss_store),
      .row(iss_row), .wdata(iss_wdata), .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld <= 1'b0; a_elem <= '0; a_bank <= '0;
    end else begin
      a_vld  <= iss_vld && !iss_store;
      a_elem <= iss_elem;
      a_bank <= iss_bank;
    end
  end

  vmem_ret_pipe #(.LAT(LOAD_LAT), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_ret (
    .clk(clk), .rst_n(rst_n), .in_vld(a_vld), .in_elem(a_elem),
    .in_data(bank_rd[a_bank]), .out_vld(rd_valid), .out_elem(rd_elem),
    .out_data(rd_data), .pending(pend)
  );

  assign busy = active | pend;

  AST_NO_ISSUE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !iss_vld && busy); // R5

endmodule

// File: tb/test_vmem_stride_unit.sv
module test_vmem_stride_unit;

  localparam int AW = 8, DW = 16, NB = 8, BUSY = 6, LAT = 12, ML = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0, is_store = 1'b0, indexed = 1'b0;
  logic [AW-1:0]   base = '0, stride = '0;
  logic [4:0]      vlen = '0;
  logic [ML*AW-1:0] idx_vec = '0;
  logic [ML*DW-1:0] wdata_vec = '0;
  logic            busy, rd_valid;
  logic [DW-1:0]   rd_data;
  logic [3:0]      rd_elem;
  logic [15:0]     stall_cycles;

  vmem_stride_unit i_vmem_stride_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store),
    .indexed(indexed), .base(base), .stride(stride), .vlen(vlen),
    .idx_vec(idx_vec), .wdata_vec(wdata_vec), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_elem(rd_elem),
    .stall_cycles(stall_cycles)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0;
  int got_n = 0;
  int got_c [32];
  int got_e [32];
  int got_d [32];
  int mem_m [256];
  int idx_arr [16];
  int wd_arr [16];
  int exp_addr [16];
  int exp_t [16];

  always @(negedge clk) begin
    if (rd_valid && got_n < 32) begin
      got_c[got_n] = cyc;
      got_e[got_n] = int'(rd_elem);
      got_d[got_n] = int'(rd_data);
      got_n = got_n + 1;
    end
  end

  function automatic int pat(input int a);
    return ((a * 16'h0101) ^ 16'h5a3c) & 16'hffff;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one command; poke > 0 pulses a conflicting start that many cycles in
  task automatic run_op(input bit st, input bit ind, input int b, input int s,
                        input int len, input int tbl_stall, input int poke,
                        input string req);
    int n, t, a, stl, k;
    int free_at [8];
    n = (len > ML) ? ML : len;
    for (int i = 0; i < 8; i++) free_at[i] = 0;
    t = 0;
    for (int i = 0; i < n; i++) begin
      exp_addr[i] = ind ? ((b + idx_arr[i]) & 255) : ((b + i * s) & 255);
      if (free_at[exp_addr[i] & 7] > t) t = free_at[exp_addr[i] & 7];
      exp_t[i] = t;
      free_at[exp_addr[i] & 7] = t + BUSY;
      t++;
    end
    stl = (n > 0) ? exp_t[n-1] - (n - 1) : 0;
    if (tbl_stall >= 0) chk(stl == tbl_stall, req, "model stall table", stl, tbl_stall);
    @(negedge clk);
    is_store = st; indexed = ind;
    base = AW'(b); stride = AW'(s); vlen = 5'(len);
    for (int i = 0; i < ML; i++) begin
      idx_vec[i*AW +: AW]   = AW'(idx_arr[i]);
      wdata_vec[i*DW +: DW] = DW'(wd_arr[i]);
    end
    start = 1'b1; a = cyc; got_n = 0;
    @(negedge clk);
    start = 1'b0;
    if (n == 0) chk(busy == 1'b0, req, "busy after empty command", int'(busy), 0);
    k = 0;
    while (busy) begin
      k++;
      if (poke > 0 && k == poke) begin
        base = 8'h40; stride = 8'd1; vlen = 5'd16; is_store = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    chk(int'(stall_cycles) == stl, req, "stall_cycles", int'(stall_cycles), stl);
    if (st) begin
      for (int i = 0; i < n; i++) mem_m[exp_addr[i]] = wd_arr[i] & 16'hffff;
      chk(got_n == 0, req, "no read data on store", got_n, 0);
    end else begin
      chk(got_n == n, req, "returned element count", got_n, n);
      for (int i = 0; i < n && i < got_n; i++) begin
        chk(got_e[i] == i, req, "element order", got_e[i], i);
        chk(got_d[i] == mem_m[exp_addr[i]], req, "load data", got_d[i], mem_m[exp_addr[i]]);
        chk(got_c[i] == a + 1 + exp_t[i] + LAT, req, "return cycle",
            got_c[i], a + 1 + exp_t[i] + LAT);
      end
    end
  endtask

  typedef struct packed {
    int b;
    int s;
    int len;
    int stl;
  } vec_t;

  // strided loads: base, stride, length, expected waiting cycles
  localparam vec_t TBL [8] = '{
    '{0,   1,   16, 0},   // R5 unit stride, no conflicts
    '{3,   8,   4,  15},  // R3 every element on one bank
    '{1,   4,   6,  8},   // R3 two banks alternate
    '{2,   2,   8,  2},   // R3 four banks, wrap back too early
    '{7,   3,   8,  0},   // R2 odd stride visits all banks
    '{200, 16,  5,  20},  // R2 address wrap, single bank
    '{5,   255, 10, 0},   // R2 negative stride
    '{0,   1,   20, 0}    // R9 length above maximum clamped
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    chk(rd_valid == 1'b0, "R1", "reset rd_valid", int'(rd_valid), 0);
    chk(stall_cycles == '0, "R1", "reset stall_cycles", int'(stall_cycles), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 fill memory with unit-stride stores
    for (int blk = 0; blk < 16; blk++) begin
      for (int i = 0; i < 16; i++) wd_arr[i] = pat(blk * 16 + i);
      run_op(1'b1, 1'b0, blk * 16, 1, 16, 0, 0, "R7");
    end

    for (int v = 0; v < 8; v++)
      run_op(1'b0, 1'b0, TBL[v].b, TBL[v].s, TBL[v].len, TBL[v].stl, 0, "R2_R3_R5_R6");

    // R4 scatter onto one bank, then gather back
    for (int i = 0; i < 16; i++) begin
      idx_arr[i] = i * 8 + 6;
      wd_arr[i]  = 16'hc000 + i;
    end
    run_op(1'b1, 1'b1, 0, 0, 6, 25, 0, "R4");
    run_op(1'b0, 1'b1, 0, 0, 6, 25, 0, "R4");
    // R4 gather spread over all banks
    for (int i = 0; i < 16; i++) idx_arr[i] = i * 9;
    run_op(1'b0, 1'b1, 100, 0, 8, 0, 0, "R4");

    // R9 start during a running command is dropped
    run_op(1'b0, 1'b0, 3, 8, 4, 15, 3, "R9");
    // R8 R9 empty command clears the counter, issues nothing
    run_op(1'b0, 1'b0, 0, 8, 0, 0, 0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule